// File: doc/BRIEF.md
# Multifunction Pin Controller

This block manages a small bank of configurable chip pins: three bidirectional pins and two input-only pins. Each pin holds a 4-bit function selection. A bidirectional pin set to an output function gets its logical level from one of three places: a general-purpose output value register, an external interrupt line or an external secondary serial-data line. A 3-bit drive-mode field then turns that level into pad-cell controls: output enable, driven value, weak pull-up and weak pull-down. Pins set to an input function pass their pad level through a two-flop synchronizer. The synchronized level then feeds a monitor vector and, where the function calls for it, one of three routed input-function outputs.

Configuration enters through a single write port that carries a pin index, a function code and a drive code. A separate port writes the output value register. The pad cells themselves are outside the block. The block only produces their control signals.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After synchronous reset, pin 0 holds function code 2 (interrupt output) and the other pins hold code 0 (disabled). Every bidirectional pin holds drive code 010, and the output value register is all zeros.
- R2: Drive code 000 on an output-function pin gives oe=0, pu=0, pd=0 for either logical level.
- R3: Drive code 001 gives oe=1 with pad_out equal to the logical level, and no pulls.
- R4: Drive code 010 drives a logical 0 actively (oe=1, out=0). A logical 1 gives oe=0 with the weak pull-up on. At no time are pu and pd both set, and a pull is never on while oe=1.
- R5: Drive code 011 drives a logical 0 actively. A logical 1 gives oe=0 with no pulls (open drain).
- R6: Drive code 100 gives the weak pull-down (oe=0) for a logical 0 and drives a logical 1 actively. Drive code 101 floats for a logical 0 and drives a logical 1 actively.
- R7: Reserved drive codes 110 and 111 give oe=0, pu=0, pd=0 for either level.
- R8: On a bidirectional pin, function code 1 takes the level from the output value register bit for that pin, code 2 from irq_level and code 3 from sdout2_level. Any other code (0, input codes 4 to 7, undefined codes 8 to 15) gives oe=0, pu=0, pd=0. pad_out is 0 whenever oe=0.
- R9: A configuration write changes the addressed pin's function (and drive, for pins 0 to 2) from the next rising edge. A write with cfg_pin of 5 or more changes nothing. A value write and a configuration write that land on the same edge both take effect.
- R10: On the input-only pins (indices 3 and 4), output codes 1 to 3 act as disabled: the monitor bit reads 0 and the pin feeds no routed output.
- R11: A pad level change reaches the monitor and the routed outputs after exactly two rising edges.
- R12: mon_level bit i carries pin i's synchronized level when its function code is 4 to 7, and 0 otherwise. Bits 0 to 2 are the bidirectional pins and bits 3 to 4 are the input-only pins.
- R13: bias_en_o (code 4), mclk_o (code 6) and sdin_o (code 7) follow the synchronized level of the lowest-index pin that selects that code. Each reads 0 when no pin selects its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pin | input | 3 | Pin index of the configuration write |
| cfg_func | input | 4 | Function code to write |
| cfg_drive | input | 3 | Drive code to write (bidirectional pins only) |
| gpo_we | input | 1 | Output value register write strobe |
| gpo_data | input | 3 | New output value register contents |
| irq_level | input | 1 | Logical level of the interrupt line |
| sdout2_level | input | 1 | Logical level of the secondary serial-data line |
| pad_in_bidir | input | 3 | Pad levels of the bidirectional pins |
| pad_in_only | input | 2 | Pad levels of the input-only pins |
| pad_oe | output | 3 | Output enable per bidirectional pad |
| pad_out | output | 3 | Driven value per bidirectional pad |
| pad_pu | output | 3 | Weak pull-up enable per bidirectional pad |
| pad_pd | output | 3 | Weak pull-down enable per bidirectional pad |
| mon_level | output | 5 | Synchronized levels of pins in an input function |
| bias_en_o | output | 1 | Routed bias-enable input |
| mclk_o | output | 1 | Routed master-clock input |
| sdin_o | output | 1 | Routed daisy-chain serial input |

## Verification
Two updates can land on the same edge. A configuration write can change a pin's function or drive code while the output value register is also being written. In the same way, a pad input can change level while its pin is being reconfigured between an input and an output function. Directed steps apply both writes in one cycle and check that the pad controls show the combined result after one edge. A long random phase also drives the configuration port, the value port and the pad inputs on every cycle. On every clock, a behavioural model of the register state and the two-stage input delay predicts all pad controls, the monitor vector and the routed outputs, and the bench compares them against the outputs.

// File: rtl/gpio_mux_pkg.sv
// Package: shared codes and pad-control encoding for the multifunction pin controller.
// Assumes function codes fit in 4 bits and drive codes in 3 bits.
package gpio_mux_pkg;

    typedef enum logic [3:0] {
        FN_OFF  = 4'd0,
        FN_GPO  = 4'd1,
        FN_IRQ  = 4'd2,
        FN_SDO2 = 4'd3,
        FN_BIAS = 4'd4,
        FN_GPI  = 4'd5,
        FN_MCLK = 4'd6,
        FN_SDIN = 4'd7
    } pin_func_e;

    typedef enum logic [2:0] {
        DRV_HIZ   = 3'd0,
        DRV_PUSH  = 3'd1,
        DRV_LO_PU = 3'd2,
        DRV_LO_Z  = 3'd3,
        DRV_PD_HI = 3'd4,
        DRV_Z_HI  = 3'd5
    } drive_mode_e;

    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
        logic pd;
    } pad_ctrl_t;

    // True for the codes that drive a pad.
    function automatic logic fn_is_output(input logic [3:0] f);
        return (f == FN_GPO) || (f == FN_IRQ) || (f == FN_SDO2);
    endfunction

    // True for the codes that sample a pad (4 to 7).
    function automatic logic fn_is_input(input logic [3:0] f);
        return (f[3] == 1'b0) && (f[2] == 1'b1);
    endfunction

    // Maps a drive code and a logical level to pad controls; reserved codes float.
    function automatic pad_ctrl_t encode_drive(input logic [2:0] d, input logic v);
        pad_ctrl_t c;
        c = '0;
        case (d)
            DRV_PUSH:  begin c.oe = 1'b1; c.out = v; end
            DRV_LO_PU: begin c.oe = !v; c.pu = v; end
            DRV_LO_Z:  begin c.oe = !v; end
            DRV_PD_HI: begin c.oe = v; c.out = v; c.pd = !v; end
            DRV_Z_HI:  begin c.oe = v; c.out = v; end
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
// Module: configuration and output value registers.
// Holds one function code per pin, one drive code per bidirectional pin and the
// output value register. Writes addressed beyond the last pin are dropped.
module gpio_cfg_regs
    import gpio_mux_pkg::*;
#(
    parameter int NUM_BIDIR = 3,
    parameter int NUM_INPUT = 2,
    parameter int IDX_W     = 3,
    localparam int NUM_PINS = NUM_BIDIR + NUM_INPUT
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [IDX_W-1:0]               cfg_pin,
    input  logic [3:0]                     cfg_func,
    input  logic [2:0]                     cfg_drive,
    input  logic                           gpo_we,
    input  logic [NUM_BIDIR-1:0]           gpo_data,
    output logic [NUM_PINS-1:0][3:0]       func_q,
    output logic [NUM_BIDIR-1:0][2:0]      drive_q,
    output logic [NUM_BIDIR-1:0]           gpo_q
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_func
        localparam logic [3:0] FN_RST = (p == 0) ? FN_IRQ : FN_OFF;
        // Function register of one pin: reset default, then addressed writes.
        always_ff @(posedge clk) begin
            if (!rst_n)
                func_q[p] <= FN_RST;
            else if (cfg_we && (cfg_pin == IDX_W'(p)))
                func_q[p] <= cfg_func;
        end
    end

    for (genvar b = 0; b < NUM_BIDIR; b++) begin : g_drive
        // Drive register of one bidirectional pin.
        always_ff @(posedge clk) begin
            if (!rst_n)
                drive_q[b] <= DRV_LO_PU;
            else if (cfg_we && (cfg_pin == IDX_W'(b)))
                drive_q[b] <= cfg_drive;
        end
    end

    // Output value register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            gpo_q <= '0;
        else if (gpo_we)
            gpo_q <= gpo_data;
    end

    p_oob_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (32'(cfg_pin) >= NUM_PINS)) |=> ($stable(func_q) && $stable(drive_q)));

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (32'(cfg_pin) < NUM_PINS)) |=> (func_q[$past(cfg_pin)] == $past(cfg_func)));

    p_reset_default_r1: assert property (@(posedge clk)
        $past(!rst_n) |-> ((func_q[0] == FN_IRQ) && (gpo_q == '0)));

endmodule

// File: rtl/gpio_in_sync.sv
// Module: multi-bit level synchronizer for pad inputs.
// Each bit passes independently through STAGES flops; it assumes the inputs are
// quasi-static levels, so no bus coherence is needed.
module gpio_in_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Shift register of sampled pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain_q <= '0;
        else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++)
                chain_q[s] <= chain_q[s-1];
        end
    end

    assign dout = chain_q[STAGES-1];

    logic [1:0] warm_q;

    // Counts edges since reset so the delay check only looks at valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            warm_q <= '0;
        else if (warm_q != 2'd2)
            warm_q <= warm_q + 2'd1;
    end

    if (STAGES == 2) begin : g_chk
        p_sync_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (warm_q == 2'd2) |-> (dout == $past(din, 2)));
    end

endmodule

// File: rtl/gpio_drive_enc.sv
// Module: pad control encoder for one bidirectional pin.
// Picks the logical level for the selected output function and turns it into pad
// controls through the drive code. Non-output functions leave the pad floating.
module gpio_drive_enc
    import gpio_mux_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] func,
    input  logic [2:0] drive,
    input  logic       gpo_bit,
    input  logic       irq_level,
    input  logic       sdout2_level,
    output logic       oe,
    output logic       out,
    output logic       pu,
    output logic       pd
);

    logic      level;
    pad_ctrl_t ctrl;

    // Select the logical level that the output function asks for.
    always_comb begin
        case (func)
            FN_GPO:  level = gpo_bit;
            FN_IRQ:  level = irq_level;
            FN_SDO2: level = sdout2_level;
            default: level = 1'b0;
        endcase
    end

    // Encode pad controls; only output functions reach the pad.
    always_comb begin
        ctrl = '0;
        if (fn_is_output(func))
            ctrl = encode_drive(drive, level);
    end

    assign oe  = ctrl.oe;
    assign out = ctrl.out;
    assign pu  = ctrl.pu;
    assign pd  = ctrl.pd;

    p_single_pad_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(pu && pd) && !(oe && (pu || pd)));

    p_hiz_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drive[2:1] == 2'b11) |-> !(oe || pu || pd));

    p_hiz_non_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_OFF || fn_is_input(func) || func[3]) |-> !(oe || pu || pd));

    p_open_drain_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (func == FN_IRQ && drive == DRV_LO_Z && irq_level) |-> !(oe || pu));

endmodule

// File: rtl/gpio_in_route.sv
// Module: input function routing.
// Masks the synchronized levels into the monitor vector and feeds each routed
// input function from the lowest-index pin that selects it.
module gpio_in_route
    import gpio_mux_pkg::*;
#(
    parameter int NUM_PINS = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PINS-1:0][3:0] func_q,
    input  logic [NUM_PINS-1:0]      sync_lvl,
    output logic [NUM_PINS-1:0]      mon_level,
    output logic                     bias_en_o,
    output logic                     mclk_o,
    output logic                     sdin_o
);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_mon
        assign mon_level[p] = fn_is_input(func_q[p]) ? sync_lvl[p] : 1'b0;

        p_mon_masked_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !fn_is_input(func_q[p]) |-> !mon_level[p]);
    end

    // Priority routing: scan from the top so the lowest-index pin wins.
    always_comb begin
        bias_en_o = 1'b0;
        mclk_o    = 1'b0;
        sdin_o    = 1'b0;
        for (int p = NUM_PINS - 1; p >= 0; p--) begin
            if (func_q[p] == FN_BIAS) bias_en_o = sync_lvl[p];
            if (func_q[p] == FN_MCLK) mclk_o    = sync_lvl[p];
            if (func_q[p] == FN_SDIN) sdin_o    = sync_lvl[p];
        end
    end

    p_mclk_lowest_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (func_q[0] == FN_MCLK) |-> (mclk_o == sync_lvl[0]));

    p_bias_lowest_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (func_q[0] == FN_BIAS) |-> (bias_en_o == sync_lvl[0]));

endmodule

// File: rtl/gpio_mux_ctrl.sv
// Module: multifunction pin controller top.
// Joins the configuration registers, one drive encoder per bidirectional pin, the
// input synchronizer and the input routing. Pad cells sit outside this block.
module gpio_mux_ctrl
    import gpio_mux_pkg::*;
#(
    parameter int NUM_BIDIR   = 3,
    parameter int NUM_INPUT   = 2,
    parameter int SYNC_STAGES = 2,
    localparam int NUM_PINS   = NUM_BIDIR + NUM_INPUT,
    localparam int IDX_W      = $clog2(NUM_PINS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_pin,
    input  logic [3:0]           cfg_func,
    input  logic [2:0]           cfg_drive,
    input  logic                 gpo_we,
    input  logic [NUM_BIDIR-1:0] gpo_data,
    input  logic                 irq_level,
    input  logic                 sdout2_level,
    input  logic [NUM_BIDIR-1:0] pad_in_bidir,
    input  logic [NUM_INPUT-1:0] pad_in_only,
    output logic [NUM_BIDIR-1:0] pad_oe,
    output logic [NUM_BIDIR-1:0] pad_out,
    output logic [NUM_BIDIR-1:0] pad_pu,
    output logic [NUM_BIDIR-1:0] pad_pd,
    output logic [NUM_PINS-1:0]  mon_level,
    output logic                 bias_en_o,
    output logic                 mclk_o,
    output logic                 sdin_o
);

    logic [NUM_PINS-1:0][3:0]  func_q;
    logic [NUM_BIDIR-1:0][2:0] drive_q;
    logic [NUM_BIDIR-1:0]      gpo_q;
    logic [NUM_PINS-1:0]       sync_lvl;

    gpio_cfg_regs #(
        .NUM_BIDIR (NUM_BIDIR),
        .NUM_INPUT (NUM_INPUT),
        .IDX_W     (IDX_W)
    ) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_pin   (cfg_pin),
        .cfg_func  (cfg_func),
        .cfg_drive (cfg_drive),
        .gpo_we    (gpo_we),
        .gpo_data  (gpo_data),
        .func_q    (func_q),
        .drive_q   (drive_q),
        .gpo_q     (gpo_q)
    );

    for (genvar b = 0; b < NUM_BIDIR; b++) begin : g_pad
        gpio_drive_enc enc_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .func         (func_q[b]),
            .drive        (drive_q[b]),
            .gpo_bit      (gpo_q[b]),
            .irq_level    (irq_level),
            .sdout2_level (sdout2_level),
            .oe           (pad_oe[b]),
            .out          (pad_out[b]),
            .pu           (pad_pu[b]),
            .pd           (pad_pd[b])
        );
    end

    gpio_in_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({pad_in_only, pad_in_bidir}),
        .dout  (sync_lvl)
    );

    gpio_in_route #(
        .NUM_PINS (NUM_PINS)
    ) route_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .func_q    (func_q),
        .sync_lvl  (sync_lvl),
        .mon_level (mon_level),
        .bias_en_o (bias_en_o),
        .mclk_o    (mclk_o),
        .sdin_o    (sdin_o)
    );

endmodule

// File: tb/gpio_mux_ctrl_tb_top.sv
`timescale 1ns/1ps
module gpio_mux_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_pin = '0;
    logic [3:0] cfg_func = '0;
    logic [2:0] cfg_drive = '0;
    logic       gpo_we = 1'b0;
    logic [2:0] gpo_data = '0;
    logic       irq_level = 1'b0;
    logic       sdout2_level = 1'b0;
    logic [2:0] pad_in_bidir = '0;
    logic [1:0] pad_in_only = '0;
    logic [2:0] pad_oe, pad_out, pad_pu, pad_pd;
    logic [4:0] mon_level;
    logic       bias_en_o, mclk_o, sdin_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gpio_mux_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pin(cfg_pin),
        .cfg_func(cfg_func), .cfg_drive(cfg_drive), .gpo_we(gpo_we),
        .gpo_data(gpo_data), .irq_level(irq_level), .sdout2_level(sdout2_level),
        .pad_in_bidir(pad_in_bidir), .pad_in_only(pad_in_only),
        .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .mon_level(mon_level), .bias_en_o(bias_en_o), .mclk_o(mclk_o), .sdin_o(sdin_o)
    );

    // Behavioural reference state.
    int m_func[5];
    int m_drv[3];
    bit m_gpo[3];
    bit m_s1[5];
    bit m_s2[5];
    bit m_valid = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected {oe,out,pu,pd} from function, drive and level.
    function automatic int exp_pad(int f, int d, bit v);
        if (f < 1 || f > 3) return 0;
        case (d)
            1: return v ? 4'b1100 : 4'b1000;
            2: return v ? 4'b0010 : 4'b1000;
            3: return v ? 4'b0000 : 4'b1000;
            4: return v ? 4'b1100 : 4'b0001;
            5: return v ? 4'b1100 : 4'b0000;
            default: return 0;
        endcase
    endfunction

    function automatic string pad_req(int f, int d);
        if (f < 1 || f > 3) return "R8";
        case (d)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4, 5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // Model update on the clock edge.
    always @(posedge clk) begin
        bit pads[5];
        pads[0] = pad_in_bidir[0]; pads[1] = pad_in_bidir[1]; pads[2] = pad_in_bidir[2];
        pads[3] = pad_in_only[0];  pads[4] = pad_in_only[1];
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin
                m_func[i] = (i == 0) ? 2 : 0;
                m_s1[i] = 0; m_s2[i] = 0;
            end
            for (int i = 0; i < 3; i++) begin m_drv[i] = 2; m_gpo[i] = 0; end
        end else begin
            for (int i = 0; i < 5; i++) begin m_s2[i] = m_s1[i]; m_s1[i] = pads[i]; end
            if (cfg_we && cfg_pin < 5) begin
                m_func[cfg_pin] = cfg_func;
                if (cfg_pin < 3) m_drv[cfg_pin] = cfg_drive;
            end
            if (gpo_we) for (int i = 0; i < 3; i++) m_gpo[i] = gpo_data[i];
        end
        m_valid = 1;
    end

    // Full comparison on every falling edge.
    always @(negedge clk) begin
        if (m_valid && !done) begin
            int e_bias, e_mclk, e_sdin, e_mon;
            bit seen_b, seen_m, seen_s;
            for (int i = 0; i < 3; i++) begin
                bit v;
                int e;
                v = (m_func[i] == 1) ? m_gpo[i] : (m_func[i] == 2) ? irq_level : sdout2_level;
                e = exp_pad(m_func[i], m_drv[i], v);
                chk({pad_oe[i], pad_out[i], pad_pu[i], pad_pd[i]} == 4'(e),
                    pad_req(m_func[i], m_drv[i]),
                    {pad_oe[i], pad_out[i], pad_pu[i], pad_pd[i]}, e);
            end
            e_mon = 0; e_bias = 0; e_mclk = 0; e_sdin = 0;
            seen_b = 0; seen_m = 0; seen_s = 0;
            for (int i = 0; i < 5; i++) begin
                if (m_func[i] >= 4 && m_func[i] <= 7 && m_s2[i]) e_mon |= (1 << i);
                if (m_func[i] == 4 && !seen_b) begin e_bias = m_s2[i]; seen_b = 1; end
                if (m_func[i] == 6 && !seen_m) begin e_mclk = m_s2[i]; seen_m = 1; end
                if (m_func[i] == 7 && !seen_s) begin e_sdin = m_s2[i]; seen_s = 1; end
            end
            chk(mon_level == 5'(e_mon), "R12 monitor", mon_level, e_mon);
            chk({bias_en_o, mclk_o, sdin_o} == 3'({e_bias[0], e_mclk[0], e_sdin[0]}),
                "R13 routed", {bias_en_o, mclk_o, sdin_o}, {e_bias[0], e_mclk[0], e_sdin[0]});
        end
    end

    task automatic wr_cfg(input int pin, input int f, input int d);
        cfg_we = 1; cfg_pin = 3'(pin); cfg_func = 4'(f); cfg_drive = 3'(d);
        @(posedge clk); #2;
        cfg_we = 0;
    endtask

    task automatic wr_both(input int pin, input int f, input int d, input int val);
        cfg_we = 1; cfg_pin = 3'(pin); cfg_func = 4'(f); cfg_drive = 3'(d);
        gpo_we = 1; gpo_data = 3'(val);
        @(posedge clk); #2;
        cfg_we = 0; gpo_we = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        @(posedge clk); #1;
        // R1: pin 0 interrupt output, drive 010; irq low drives 0 strongly.
        chk(pad_oe[0] && !pad_out[0], "R1 irq default low", {pad_oe[0], pad_out[0]}, 2'b10);
        chk(pad_oe[2:1] == 2'b00 && pad_pu[2:1] == 2'b00, "R1 others disabled", {pad_oe, pad_pu}, 0);
        irq_level = 1; #1;
        chk(!pad_oe[0] && pad_pu[0], "R1 irq high weak pull-up", {pad_oe[0], pad_pu[0]}, 2'b01);
        @(posedge clk); #2;

        // Sweep R2..R8 over every drive and output function.
        for (int p = 0; p < 3; p++)
            for (int d = 0; d < 8; d++)
                for (int f = 1; f < 4; f++) begin
                    wr_cfg(p, f, d);
                    for (int v = 0; v < 2; v++) begin
                        gpo_we = 1; gpo_data = {3{v[0]}}; irq_level = v[0]; sdout2_level = v[0];
                        @(posedge clk); #2; gpo_we = 0;
                        @(posedge clk); #2;
                    end
                end
        // R8: non-output codes float the pad.
        for (int f = 0; f < 16; f++) begin
            if (f >= 1 && f <= 3) continue;
            wr_cfg(1, f, 1);
            @(posedge clk); #1;
            chk(!pad_oe[1] && !pad_pu[1] && !pad_pd[1], "R8 non-output floats", pad_oe[1], 0);
            #1;
        end

        // R9: out-of-range write changes nothing.
        wr_both(0, 1, 1, 3'b111);
        wr_cfg(5, 0, 0);
        wr_cfg(7, 0, 0);
        #1;
        chk(pad_oe[0] && pad_out[0], "R9 out-of-range ignored", {pad_oe[0], pad_out[0]}, 2'b11);
        #1;
        // R9: same-edge value and config writes both land.
        wr_both(2, 1, 3, 3'b000);
        #1;
        chk(pad_oe[2] && !pad_out[2], "R9 same-edge open drain low", {pad_oe[2], pad_out[2]}, 2'b10);
        #1;
        wr_both(2, 1, 4, 3'b100);
        #1;
        chk(pad_oe[2] && pad_out[2], "R9 same-edge drive high", {pad_oe[2], pad_out[2]}, 2'b11);
        #1;

        // R11: two-edge latency through the synchronizer.
        wr_cfg(3, 5, 0);
        pad_in_only[0] = 0;
        repeat (3) @(posedge clk);
        #2 pad_in_only[0] = 1;
        @(posedge clk); #1;
        chk(mon_level[3] == 0, "R11 one edge not yet", mon_level[3], 0);
        @(posedge clk); #1;
        chk(mon_level[3] == 1, "R11 after two edges", mon_level[3], 1);
        #1;

        // R10: output codes on an input-only pin act as disabled.
        wr_cfg(4, 1, 1);
        pad_in_only[1] = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(mon_level[4] == 0, "R10 input-only output code", mon_level[4], 0);
        #1;

        // R13: two pins select master clock; lower index wins.
        wr_cfg(1, 6, 0);
        wr_cfg(3, 6, 0);
        pad_in_bidir[1] = 0; pad_in_only[0] = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(mclk_o == 0, "R13 lowest index wins", mclk_o, 0);
        #1;
        pad_in_bidir[1] = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(mclk_o == 1, "R13 follows pin 1", mclk_o, 1);
        chk(sdin_o == 0, "R13 unselected reads 0", sdin_o, 0);
        #1;

        // Random phase: config, values and pads change together (R9, R11, R12, R13).
        for (int n = 0; n < 600; n++) begin
            cfg_we = $urandom_range(0, 2) == 0;
            cfg_pin = 3'($urandom_range(0, 7));
            cfg_func = 4'($urandom_range(0, 15));
            cfg_drive = 3'($urandom_range(0, 7));
            gpo_we = $urandom_range(0, 3) == 0;
            gpo_data = 3'($urandom);
            irq_level = 1'($urandom);
            sdout2_level = 1'($urandom);
            pad_in_bidir = 3'($urandom);
            pad_in_only = 2'($urandom);
            @(posedge clk); #2;
        end
        cfg_we = 0; gpo_we = 0;
        @(posedge clk); #2;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule